// File: doc/BRIEF.md
# Keyboard and Display Port Controller

This block is a bus slave that connects one character source (a keyboard) and one character sink (a display) to a simple processor bus. The bus has an address, write data, one-cycle read and write strobes, and read data. The block decodes a window of four word addresses above a configurable base. Inside that window it exposes an input character register, an output character register, a status register and an interrupt-enable register.

Device events set the ready flags. A keyboard character arrives through a valid/data pulse. A character leaves for the display through a valid/ready handshake. Processor accesses to the character registers clear the flags again, so reading or writing the data also serves as the acknowledgement. A per-device request bit is the AND of a ready flag and its enable bit. The single interrupt line is the OR of the two request bits. A keyboard character that arrives before the previous one was read replaces it and leaves a sticky overrun mark, which a status read clears.

Top module: `kbd_disp_port`

## Requirements
- R1: The registers sit at BASE_ADDR+0 (input character), +1 (output character), +2 (status) and +3 (enables). Outside that window, an access changes no state, and read data is 0 whenever no read hits the window.
- R2: After reset: the status reads 0x02 (only output-ready set), the enables read 0, irq is 0 and disp_valid is 0.
- R3: A cycle with kb_valid high loads kb_char into the input register and sets status bit 0 (input-ready) at that clock edge.
- R4: A read at offset 0 returns the held character, combinationally during the strobe, and clears status bit 0 at the edge that ends the strobe. If kb_valid is high in that same cycle, the new character is stored and bit 0 stays 1.
- R5: A write at offset 1 loads the character, drives it on disp_char with disp_valid high, and clears status bit 1 (output-ready). disp_char and disp_valid hold until a cycle with disp_valid and disp_ready both high. After that cycle bit 1 is 1 and disp_valid is 0. A write in the same cycle as the handshake keeps disp_valid high with the new character.
- R6: The enables register uses bit 0 as the keyboard interrupt enable and bit 1 as the display interrupt enable. Its other bits read as 0.
- R7: Status bit 6 equals bit 0 AND the keyboard enable. Status bit 7 equals bit 1 AND the display enable. irq equals bit 6 OR bit 7.
- R8: If kb_valid arrives while bit 0 is set and no offset-0 read happens in that cycle, the character is replaced and status bit 2 (overrun) becomes 1. A status read clears bit 2 at the edge that ends it, unless a new overrun happens in that same cycle.
- R9: Writes at offset 2 and offset 0 have no effect. Status bits 3, 4 and 5 read as 0.
- R10: A read at offset 1 returns the character most recently written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | DATA_W | Bus write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | DATA_W | Read data, valid during the read strobe |
| irq | output | 1 | Combined interrupt request |
| kb_valid | input | 1 | Keyboard character strobe |
| kb_char | input | DATA_W | Keyboard character |
| disp_valid | output | 1 | Character pending for the display |
| disp_char | output | DATA_W | Character for the display |
| disp_ready | input | 1 | Display accepts the pending character |

## Verification
Two pairs of events can fall in the same clock cycle. The first pair is a keyboard arrival and a processor read of the input character. The second pair is a processor write of the output character and the display's acceptance of the previous one. The bench drives both halves of each pair on the same edge. For the first pair it checks that the read returns the old character and that the new character stays pending with no overrun. For the second pair it checks that the display sees the old character accepted and the new one still offered. A third collision, an overrun on the same cycle as a status read, is judged by whether the overrun mark survives.

// File: rtl/kdp_pkg.sv
package kdp_pkg;
  localparam int REG_COUNT = 4;
  localparam int OFS_W     = $clog2(REG_COUNT);

  typedef enum logic [OFS_W-1:0] {
    SEL_IN   = 2'd0,
    SEL_OUT  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  // status bit positions
  localparam int ST_IN_RDY  = 0;
  localparam int ST_OUT_RDY = 1;
  localparam int ST_OVR     = 2;
  localparam int ST_KREQ    = 6;
  localparam int ST_DREQ    = 7;

  // enable bit positions
  localparam int EN_KEY  = 0;
  localparam int EN_DISP = 1;
  localparam int EN_W    = 2;

  function automatic logic req_of(input logic flag, input logic en);
    return flag & en;
  endfunction
endpackage

// File: rtl/kdp_decode.sv
module kdp_decode
  import kdp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic              hit,
  output reg_sel_e          sel,
  output logic              rd_hit,
  output logic              take_in,
  output logic              load_out,
  output logic              rd_stat,
  output logic              wr_ctrl
);
  assign hit      = (addr[ADDR_W-1:OFS_W] == BASE_ADDR[ADDR_W-1:OFS_W]);
  assign sel      = reg_sel_e'(addr[OFS_W-1:0]);
  assign rd_hit   = rd & hit;
  assign take_in  = rd_hit & (sel == SEL_IN);
  assign rd_stat  = rd_hit & (sel == SEL_STAT);
  assign load_out = wr & hit & (sel == SEL_OUT);
  assign wr_ctrl  = wr & hit & (sel == SEL_CTRL);

  AST_DEC_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_in, rd_stat, wr_ctrl}) && $onehot0({take_in, load_out})); // R1
  AST_DEC_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> !(take_in || load_out || rd_stat || wr_ctrl)); // R1
endmodule

// File: rtl/kdp_rx_chan.sv
module kdp_rx_chan #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kb_valid,
  input  logic [DATA_W-1:0] kb_char,
  input  logic              take,
  input  logic              clr_ovr,
  output logic [DATA_W-1:0] data,
  output logic              in_ready,
  output logic              overrun,
  output logic              ovr_event
);
  logic ready_nxt, ovr_nxt;

  assign ovr_event = kb_valid & in_ready & ~take;
  assign ready_nxt = kb_valid | (in_ready & ~take);
  assign ovr_nxt   = ovr_event | (overrun & ~clr_ovr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data     <= '0;
      in_ready <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (kb_valid) data <= kb_char;
      in_ready <= ready_nxt;
      overrun  <= ovr_nxt;
    end
  end

  AST_RX_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
    kb_valid |=> in_ready && data == $past(kb_char)); // R3
  AST_RX_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    take && !kb_valid |=> !in_ready); // R4
  AST_RX_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    kb_valid && in_ready && !take |=> overrun); // R8
  AST_RX_OVERRUN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ovr && !ovr_event |=> !overrun); // R8
endmodule

// File: rtl/kdp_tx_chan.sv
module kdp_tx_chan #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  input  logic              disp_ready,
  output logic              disp_valid,
  output logic [DATA_W-1:0] disp_char,
  output logic              out_ready,
  output logic              accept
);
  assign accept    = disp_valid & disp_ready;
  assign out_ready = ~disp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_valid <= 1'b0;
      disp_char  <= '0;
    end else begin
      if (load) disp_char <= wdata;
      disp_valid <= load | (disp_valid & ~accept);
    end
  end

  AST_TX_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !out_ready && disp_char == $past(wdata)); // R5
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && !disp_ready && !load |=> disp_valid && $stable(disp_char)); // R5
  AST_TX_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !load |=> out_ready); // R5
endmodule

// File: rtl/kbd_disp_port.sv
module kbd_disp_port
  import kdp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  input  logic              kb_valid,
  input  logic [DATA_W-1:0] kb_char,
  output logic              disp_valid,
  output logic [DATA_W-1:0] disp_char,
  input  logic              disp_ready
);
  logic              hit, rd_hit, take_in, load_out, rd_stat, wr_ctrl;
  reg_sel_e          sel;
  logic [DATA_W-1:0] in_data;
  logic              in_ready, overrun, ovr_event;
  logic              out_ready, accept;
  logic [EN_W-1:0]   en_reg;
  logic              key_req, disp_req;
  logic [DATA_W-1:0] status_word, ctrl_word;

  function automatic logic [DATA_W-1:0] pack_status(
    input logic ir, input logic orr, input logic ov,
    input logic kq, input logic dq);
    logic [DATA_W-1:0] s;
    s = '0;
    s[ST_IN_RDY]  = ir;
    s[ST_OUT_RDY] = orr;
    s[ST_OVR]     = ov;
    s[ST_KREQ]    = kq;
    s[ST_DREQ]    = dq;
    return s;
  endfunction

  kdp_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .hit(hit), .sel(sel), .rd_hit(rd_hit), .take_in(take_in),
    .load_out(load_out), .rd_stat(rd_stat), .wr_ctrl(wr_ctrl));

  kdp_rx_chan #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .kb_valid(kb_valid), .kb_char(kb_char),
    .take(take_in), .clr_ovr(rd_stat), .data(in_data),
    .in_ready(in_ready), .overrun(overrun), .ovr_event(ovr_event));

  kdp_tx_chan #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(load_out), .wdata(bus_wdata),
    .disp_ready(disp_ready), .disp_valid(disp_valid), .disp_char(disp_char),
    .out_ready(out_ready), .accept(accept));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_reg <= '0;
    else if (wr_ctrl) en_reg <= bus_wdata[EN_W-1:0];
  end

  assign key_req  = req_of(in_ready, en_reg[EN_KEY]);
  assign disp_req = req_of(out_ready, en_reg[EN_DISP]);
  assign irq      = key_req | disp_req;

  assign status_word = pack_status(in_ready, out_ready, overrun, key_req, disp_req);
  assign ctrl_word   = {{(DATA_W-EN_W){1'b0}}, en_reg};

  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      unique case (sel)
        SEL_IN:   bus_rdata = in_data;
        SEL_OUT:  bus_rdata = disp_char;
        SEL_STAT: bus_rdata = status_word;
        SEL_CTRL: bus_rdata = ctrl_word;
        default:  bus_rdata = '0;
      endcase
    end
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    en_reg == '0 |-> !irq); // R7
  AST_IRQ_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && en_reg[EN_KEY] |-> irq); // R7
  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> bus_rdata == '0); // R1
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(en_reg)); // R6
endmodule

// File: tb/kbd_disp_port_bench.sv
module kbd_disp_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] BASE = 16'h4000;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [DATA_W-1:0] bus_rdata;
  logic irq;
  logic kb_valid = 1'b0;
  logic [DATA_W-1:0] kb_char = '0;
  logic disp_valid;
  logic [DATA_W-1:0] disp_char;
  logic disp_ready = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbd_disp_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE)) u_kbd_disp_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .irq(irq),
    .kb_valid(kb_valid), .kb_char(kb_char), .disp_valid(disp_valid),
    .disp_char(disp_char), .disp_ready(disp_ready));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic key(input logic [DATA_W-1:0] c);
    @(negedge clk);
    kb_valid = 1'b1; kb_char = c;
    @(negedge clk);
    kb_valid = 1'b0;
  endtask

  task automatic accept_disp();
    @(negedge clk);
    disp_ready = 1'b1;
    @(negedge clk);
    disp_ready = 1'b0;
  endtask

  function automatic logic [7:0] exp_status(bit ir, bit orr, bit ov, logic [1:0] en);
    return {orr & en[1], ir & en[0], 3'b000, ov, orr, ir};
  endfunction

  initial begin
    logic [DATA_W-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    check(irq == 1'b0, "R2 irq", irq, 0);
    check(disp_valid == 1'b0, "R2 disp_valid", disp_valid, 0);
    rd_reg(BASE + 2, d); check(d == 8'h02, "R2 status", d, 8'h02);
    rd_reg(BASE + 3, d); check(d == 8'h00, "R2 enables", d, 0);

    // R3 / R4 basic receive
    key(8'h41);
    rd_reg(BASE + 2, d); check(d[0] == 1'b1, "R3 input-ready", d, 8'h03);
    rd_reg(BASE + 0, d); check(d == 8'h41, "R4 data", d, 8'h41);
    rd_reg(BASE + 2, d); check(d == 8'h02, "R4 cleared", d, 8'h02);

    // R6 enable width
    wr_reg(BASE + 3, 8'hFF);
    rd_reg(BASE + 3, d); check(d == 8'h03, "R6 enables readback", d, 8'h03);

    // R7 sweep: enables x input-ready x output-ready
    for (int en = 0; en < 4; en++) begin
      for (int ir = 0; ir < 2; ir++) begin
        for (int orr = 0; orr < 2; orr++) begin
          logic [7:0] e;
          wr_reg(BASE + 3, 8'(en));
          if (ir == 1) key(8'h60 + 8'(en));
          if (orr == 0) wr_reg(BASE + 1, 8'h30);
          e = exp_status(ir[0], orr[0], 1'b0, 2'(en));
          check(irq == (e[6] | e[7]), "R7 irq sweep", irq, 32'(e[6] | e[7]));
          rd_reg(BASE + 2, d);
          check(d == e, "R7 status sweep", d, e);
          if (ir == 1) rd_reg(BASE + 0, d);
          if (orr == 0) accept_disp();
        end
      end
    end
    wr_reg(BASE + 3, 8'h00);

    // R8 overrun
    key(8'h11); key(8'h22);
    rd_reg(BASE + 2, d); check(d == 8'h07, "R8 overrun set", d, 8'h07);
    rd_reg(BASE + 2, d); check(d == 8'h03, "R8 overrun cleared", d, 8'h03);
    rd_reg(BASE + 0, d); check(d == 8'h22, "R8 data replaced", d, 8'h22);

    // R4 read colliding with arrival
    key(8'h51);
    @(negedge clk);
    bus_addr = BASE; bus_rd = 1'b1; kb_valid = 1'b1; kb_char = 8'h52;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; kb_valid = 1'b0;
    check(d == 8'h51, "R4 collide old data", d, 8'h51);
    rd_reg(BASE + 2, d); check(d == 8'h03, "R4 collide ready kept no overrun", d, 8'h03);
    rd_reg(BASE + 0, d); check(d == 8'h52, "R4 collide new data", d, 8'h52);

    // R8 overrun colliding with status read
    key(8'h71); key(8'h72);
    @(negedge clk);
    bus_addr = BASE + 2; bus_rd = 1'b1; kb_valid = 1'b1; kb_char = 8'h73;
    @(negedge clk);
    bus_rd = 1'b0; kb_valid = 1'b0;
    rd_reg(BASE + 2, d); check(d[2] == 1'b1, "R8 overrun survives status read", d, 8'h07);
    rd_reg(BASE + 0, d);
    rd_reg(BASE + 2, d); check(d == 8'h02, "R8 cleanup", d, 8'h02);

    // R5 transmit
    wr_reg(BASE + 1, 8'h51);
    check(disp_valid && disp_char == 8'h51, "R5 presented", disp_char, 8'h51);
    repeat (3) @(negedge clk);
    check(disp_valid && disp_char == 8'h51, "R5 held", disp_char, 8'h51);
    rd_reg(BASE + 2, d); check(d == 8'h00, "R5 output busy", d, 0);
    rd_reg(BASE + 1, d); check(d == 8'h51, "R10 readback", d, 8'h51);
    accept_disp();
    check(disp_valid == 1'b0, "R5 released", disp_valid, 0);
    rd_reg(BASE + 2, d); check(d == 8'h02, "R5 output ready", d, 8'h02);

    // R5 write colliding with display acceptance
    wr_reg(BASE + 1, 8'h61);
    @(negedge clk);
    bus_addr = BASE + 1; bus_wdata = 8'h62; bus_wr = 1'b1; disp_ready = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; disp_ready = 1'b0;
    check(disp_valid && disp_char == 8'h62, "R5 collide new char", disp_char, 8'h62);
    accept_disp();

    // R9 ignored writes
    key(8'h33);
    wr_reg(BASE + 2, 8'hFF);
    rd_reg(BASE + 2, d); check(d == 8'h03, "R9 status write ignored", d, 8'h03);
    wr_reg(BASE + 0, 8'h99);
    rd_reg(BASE + 0, d); check(d == 8'h33, "R9 input write ignored", d, 8'h33);

    // R1 outside the window
    wr_reg(BASE + 4, 8'h03);
    wr_reg(BASE - 1, 8'h03);
    rd_reg(BASE + 3, d); check(d == 8'h00, "R1 outside write", d, 0);
    rd_reg(BASE + 5, d); check(d == 8'h00, "R1 outside read", d, 0);
    wr_reg(BASE + 5, 8'h44);
    check(disp_valid == 1'b0, "R1 outside no transmit", disp_valid, 0);
    @(negedge clk);
    check(bus_rdata == 8'h00, "R1 idle read data", bus_rdata, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule